// File: doc/BRIEF.md
# Guard Soak Timer Qualifier

This block decides whether one timing reference can be trusted. It takes failure events from two neighbouring monitors, one that checks single clock periods and one that checks the coarse frequency. A 16-bit leaky integrator accumulates these events. While any unmasked failure is present, the integrator climbs by a step of `n` on each timebase tick. While no failure is present, it drains by one per tick. When it reaches the upper threshold, the block raises a fail flag. The flag stays high until the integrator has drained all the way to zero.

Two settings shape the timing. The disqualification setting sets the time `t_d` that continuous failure needs to raise the flag. The multiplier `n` makes the recovery time `n * t_d`. The upper threshold is therefore `t_d` (in ticks) times `n`. The integrator is clamped at zero and at the upper threshold. Between those two points the flag keeps its last value, which gives the block its hysteresis. Each failure source has a mask bit that removes it from the integrator.

Top module: `gst_qualifier`

## Requirements
- R1: On a tick where at least one unmasked failure input is high, the integrator rises by the step `n`. With `rst` released and a tick on every cycle, `gst_fail` rises on exactly the `t_d`-th rising clock edge of continuous failure, starting from an empty integrator.
- R2: `disq_code` value c selects `t_d = 2^c` ms (1, 2, 4 or 8 ms). One ms lasts `TICKS_PER_MS` ticks.
- R3: On a tick with no unmasked failure, the integrator drains by exactly one. Starting from a full integrator, `gst_fail` falls on exactly the `t_d * n`-th tick.
- R4: `mult_code` values 0, 1, 2 and 3 select `n` = 4, 16, 32 and 64 respectively.
- R5: `fail_mask` bit i set to 1 removes `fail_in` bit i from the integrator. Bit 0 is the period monitor and bit 1 is the frequency monitor. A masked failure leaves the integrator untouched.
- R6: The integrator saturates at the upper threshold `t_d * n` (in ticks) and at zero. Further failure past the threshold does not lengthen the recovery time.
- R7: Between the thresholds `gst_fail` holds its value. A set flag stays high through partial drains. A clear flag stays low through partial rises.
- R8: On cycles where `tick` is low, neither the integrator nor `gst_fail` changes.
- R9: A synchronous, active-high `rst` empties the integrator and drives `gst_fail` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, `TICKS_PER_MS` per ms |
| fail_in | input | NUM_SRC | Failure events: bit 0 is the period monitor, bit 1 is the frequency monitor |
| fail_mask | input | NUM_SRC | 1 excludes the matching failure input |
| disq_code | input | 2 | Disqualification time select |
| mult_code | input | 2 | Qualification multiplier select |
| gst_fail | output | 1 | Reference disqualified |

## Verification
The bound checker watches the integrator on every cycle. It checks that the integrator holds when no tick arrives and drains by exactly one on a tick with no unmasked failure. It checks that the integrator rises and stays clamped when a failure arrives. It also checks that the flag can fall only when the integrator is empty and can rise only when it is non-empty. The exact rise and recovery durations for every one of the sixteen time settings can only be shown by the bench's sweeps. The same holds for the preserved hysteresis across partial excursions, the clamp's effect on recovery length, and the untouched integrator after masked failures.

// File: rtl/gst_pkg.sv
package gst_pkg;

    localparam int GST_ACC_W  = 16;
    localparam int GST_STEP_W = 7;

    typedef logic [GST_ACC_W-1:0]  acc_t;
    typedef logic [GST_STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        MULT_X4  = 2'd0,
        MULT_X16 = 2'd1,
        MULT_X32 = 2'd2,
        MULT_X64 = 2'd3
    } mult_e;

    typedef struct packed {
        acc_t  upper;
        step_t step;
    } gst_cfg_t;

    function automatic int unsigned disq_ms(input logic [1:0] code);
        return 32'd1 << code;
    endfunction

    function automatic step_t mult_of(input mult_e code);
        case (code)
            MULT_X4:  return step_t'(4);
            MULT_X16: return step_t'(16);
            MULT_X32: return step_t'(32);
            default:  return step_t'(64);
        endcase
    endfunction

endpackage

// File: rtl/gst_cfg_decode.sv
module gst_cfg_decode
    import gst_pkg::*;
#(
    parameter int TICKS_PER_MS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] disq_code,
    input  logic [1:0] mult_code,
    output gst_cfg_t   cfg_q
);
    gst_cfg_t    cfg_d;
    int unsigned td_ticks;

    always_comb begin
        td_ticks    = disq_ms(disq_code) * TICKS_PER_MS;
        cfg_d.step  = mult_of(mult_e'(mult_code));
        cfg_d.upper = acc_t'(td_ticks * 32'(cfg_d.step));
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= cfg_d;
        else     cfg_q <= cfg_d;
    end
endmodule

// File: rtl/gst_event_merge.sv
module gst_event_merge #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] fail_in,
    input  logic [NUM_SRC-1:0] fail_mask,
    output logic               any_fail
);
    logic [NUM_SRC-1:0] live;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign live[i] = fail_in[i] & ~fail_mask[i];
    end

    assign any_fail = |live;
endmodule

// File: rtl/gst_accum.sv
module gst_accum
    import gst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     any_fail,
    input  gst_cfg_t cfg,
    output acc_t     acc_q,
    output logic     fail_q
);
    logic [GST_ACC_W:0] sum;
    acc_t               acc_n;

    always_comb begin
        sum = {1'b0, acc_q} + (GST_ACC_W+1)'(cfg.step);
        if (any_fail)
            acc_n = (sum >= {1'b0, cfg.upper}) ? cfg.upper : sum[GST_ACC_W-1:0];
        else
            acc_n = (acc_q == '0) ? '0 : acc_q - acc_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            fail_q <= 1'b0;
        end else if (tick) begin
            acc_q <= acc_n;
            if (acc_n >= cfg.upper) fail_q <= 1'b1;
            else if (acc_n == '0)   fail_q <= 1'b0;
        end
    end
endmodule

// File: rtl/gst_qualifier.sv
module gst_qualifier
    import gst_pkg::*;
#(
    parameter int NUM_SRC      = 2,
    parameter int TICKS_PER_MS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NUM_SRC-1:0] fail_in,
    input  logic [NUM_SRC-1:0] fail_mask,
    input  logic [1:0]         disq_code,
    input  logic [1:0]         mult_code,
    output logic               gst_fail
);
    gst_cfg_t cfg_q;
    logic     any_fail;
    acc_t     acc_q;
    acc_t     upper_q;

    gst_cfg_decode #(.TICKS_PER_MS(TICKS_PER_MS)) u_cfg (
        .clk(clk), .rst(rst), .disq_code(disq_code),
        .mult_code(mult_code), .cfg_q(cfg_q)
    );

    gst_event_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .fail_in(fail_in), .fail_mask(fail_mask), .any_fail(any_fail)
    );

    gst_accum u_acc (
        .clk(clk), .rst(rst), .tick(tick), .any_fail(any_fail),
        .cfg(cfg_q), .acc_q(acc_q), .fail_q(gst_fail)
    );

    assign upper_q = cfg_q.upper;
endmodule

// File: rtl/gst_qualifier_chk.sv
module gst_qualifier_chk
    import gst_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic [NUM_SRC-1:0] fail_in,
    input logic [NUM_SRC-1:0] fail_mask,
    input acc_t               acc_q,
    input acc_t               upper_q,
    input logic               gst_fail
);
    logic hit;
    assign hit = |(fail_in & ~fail_mask);

    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(acc_q) && $stable(gst_fail)));

    p_drain_one_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !hit && acc_q != '0) |=> (acc_q == $past(acc_q) - acc_t'(1)));

    p_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && hit && acc_q < upper_q) |=> (acc_q > $past(acc_q)));

    p_clamp_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && hit) |=> (acc_q <= $past(upper_q)));

    p_fall_empty_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(gst_fail) |-> (acc_q == '0));

    p_rise_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(gst_fail) |-> (acc_q != '0));

    p_empty_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (acc_q == '0) |-> !gst_fail);
endmodule

bind gst_qualifier gst_qualifier_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .fail_in(fail_in),
    .fail_mask(fail_mask), .acc_q(acc_q), .upper_q(upper_q),
    .gst_fail(gst_fail)
);

// File: tb/gst_qualifier_tb.sv
module gst_qualifier_tb;
    localparam int TPM = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] fail_in = 2'b00;
    logic [1:0] fail_mask = 2'b00;
    logic [1:0] disq_code = 2'd0;
    logic [1:0] mult_code = 2'd0;
    logic       gst_fail;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gst_qualifier #(.NUM_SRC(2), .TICKS_PER_MS(TPM)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .fail_in(fail_in),
        .fail_mask(fail_mask), .disq_code(disq_code),
        .mult_code(mult_code), .gst_fail(gst_fail)
    );

    function automatic int n_of(input int c);
        case (c)
            0: return 4;
            1: return 16;
            2: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic do_reset(input int d, input int m);
        @(negedge clk);
        disq_code = 2'(d); mult_code = 2'(m);
        fail_in = 2'b00; fail_mask = 2'b00; tick = 1'b0; rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        cycles(1);
    endtask

    task automatic edges_until(input logic lvl, input int lim, output int n);
        n = 0;
        while (gst_fail !== lvl && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    int cnt;

    initial begin
        do_reset(0, 0);
        check("R9 reset flag", int'(gst_fail), 0);

        // R2 R4 R1 R3: every time setting, full rise and full recovery
        for (int d = 0; d < 4; d++) begin
            for (int m = 0; m < 4; m++) begin
                int td;
                td = (1 << d) * TPM;
                do_reset(d, m);
                tick = 1'b1; fail_in = 2'b01;
                edges_until(1'b1, 4 * td + 10, cnt);
                check($sformatf("R1 R2 rise d=%0d m=%0d", d, m), cnt, td);
                fail_in = 2'b00;
                edges_until(1'b0, 2 * td * n_of(m) + 10, cnt);
                check($sformatf("R3 R4 recover d=%0d m=%0d", d, m), cnt, td * n_of(m));
            end
        end

        // R7 hysteresis, t_d = 4, n = 4, upper = 16
        do_reset(2, 0);
        tick = 1'b1; fail_in = 2'b10;
        cycles(3);
        check("R7 partial rise keeps flag low", int'(gst_fail), 0);
        fail_in = 2'b00; cycles(5);
        check("R7 partial drain keeps flag low", int'(gst_fail), 0);
        fail_in = 2'b10;
        edges_until(1'b1, 20, cnt);
        check("R7 resumed rise from 7", cnt, 3);
        fail_in = 2'b00; cycles(10);
        check("R7 partial drain keeps flag high", int'(gst_fail), 1);
        fail_in = 2'b01; cycles(1);
        fail_in = 2'b00;
        edges_until(1'b0, 40, cnt);
        check("R7 drain from 10", cnt, 10);

        // R6 saturation: long failure does not extend recovery
        fail_in = 2'b11; cycles(25);
        fail_in = 2'b00;
        edges_until(1'b0, 40, cnt);
        check("R6 recovery after saturation", cnt, 16);

        // R5 masking
        do_reset(2, 0);
        tick = 1'b1; fail_mask = 2'b11; fail_in = 2'b11;
        cycles(50);
        check("R5 both masked flag", int'(gst_fail), 0);
        fail_mask = 2'b00; fail_in = 2'b01;
        edges_until(1'b1, 20, cnt);
        check("R5 full rise after masked period", cnt, 4);
        do_reset(2, 0);
        tick = 1'b1; fail_mask = 2'b01; fail_in = 2'b01;
        cycles(30);
        check("R5 period source masked", int'(gst_fail), 0);
        fail_in = 2'b11;
        edges_until(1'b1, 20, cnt);
        check("R5 frequency source alone", cnt, 4);

        // R8 tick gating
        do_reset(1, 1);
        tick = 1'b0; fail_in = 2'b01;
        cycles(100);
        check("R8 no tick no rise", int'(gst_fail), 0);
        tick = 1'b1;
        edges_until(1'b1, 20, cnt);
        check("R8 rise after ticks resume", cnt, 2);
        tick = 1'b0; fail_in = 2'b00;
        cycles(100);
        check("R8 no tick no drain", int'(gst_fail), 1);
        tick = 1'b1;
        edges_until(1'b0, 100, cnt);
        check("R8 R3 drain after ticks resume", cnt, 32);

        // R9 reset mid-flight
        fail_in = 2'b01; cycles(2);
        check("R9 flag set before reset", int'(gst_fail), 1);
        rst = 1'b1; cycles(1);
        check("R9 reset clears flag", int'(gst_fail), 0);
        rst = 1'b0; fail_in = 2'b00;
        cycles(1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule